// File: doc/BRIEF.md
# Floating-Point Status and Compare Queue Unit

This unit keeps the 32-bit floating-point status word for an FPU pipeline. From that word it drives a two-bit rounding-mode control and a flush-to-zero control. When an arithmetic operation completes, the unit ORs the five exception flags that operation raised into a sticky field at the top of the word. If any raised flag has its enable bit set in the low five bits of the word, the unit raises a trap request for one cycle.

Compare results are recorded in one of two ways. A nonzero target index writes the chosen result into one addressed condition bit. A zero index pushes the result into a primary condition bit, and the old primary bit and a ten-bit history shift down one place. On a compare, any exception flags the compare raised are merged first, and the result is recorded after that. A direct register write takes priority over both kinds of update in the same cycle.

Top module: `fpStatusUnit`

## Requirements
- R1: During and after reset, and before any other stimulus, statusWord, roundMode, flushEn and trapReq are all zero.
- R2: When wrEn is high, statusWord takes wrData at the next clock edge. Any opDone or cmpDone in the same cycle has no effect on the word, and no trap follows it.
- R3: roundMode always equals statusWord[10:9] (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity), and flushEn always equals statusWord[5].
- R4: On opDone, raised flag bit k of opFlags (0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) is ORed into statusWord[27+k]. These bits are sticky: only a write clears them.
- R5: An opDone with opFlags equal to zero leaves statusWord unchanged.
- R6: trapReq is high for the single cycle after an opDone or cmpDone whose opFlags ANDed with statusWord[4:0] is nonzero. In every other cycle it is low.
- R7: The recorded compare result is cmpMask bit 4 when cmpRel is 0 (greater), bit 3 when 1 (less), bit 2 when 2 (equal), and bit 1 when 3 (unordered). Mask bit 0 chooses signaling or quiet compare and never changes the recorded value.
- R8: On cmpDone with cmpTarget y in 1..11, the result is written to statusWord[22-y]. All other condition and queue bits keep their values.
- R9: On cmpDone with cmpTarget 0, bits 20:11 take the old bits 21:12, bit 21 takes the old bit 26, and bit 26 takes the new result.
- R10: On cmpDone, opFlags is merged into bits 31:27 and can raise a trap exactly as on opDone. The compare result is then recorded on top of the merged word.
- R11: On cmpDone with cmpTarget in 12..15, no condition bit changes. Flags are still merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Direct write of the status word |
| wrData | input | 32 | Value for a direct write |
| opDone | input | 1 | Arithmetic operation completed |
| opFlags | input | 5 | Exception flags raised by the completing operation or compare |
| cmpDone | input | 1 | Compare completed |
| cmpRel | input | 2 | Compare relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmpMask | input | 5 | Condition mask; bits 4..1 select per relation, bit 0 selects signaling |
| cmpTarget | input | 4 | 0 pushes the queue; 1..11 address a condition bit |
| statusWord | output | 32 | Current status word |
| roundMode | output | 2 | Rounding-mode control |
| flushEn | output | 1 | Flush denormals to zero |
| trapReq | output | 1 | One-cycle trap request |

## Verification
The bench aims at the bit arithmetic of the compare paths. It uses targets 1 and 11 to catch an off-by-one in the target index, which would mark the wrong bit or run into the queue. It checks that a queue push moves the old primary bit into bit 21 rather than dropping it, and that bit 11 falls off the end of the history. It runs a compare that raises flags and pushes in the same cycle, so a design that orders these steps wrongly, or ignores flags on compares, leaves a wrong word or misses the trap. It also checks write priority, flagless operations, raised flags whose enable is clear, and out-of-range targets, which a careless design would let change the word or trap.

// File: rtl/fpsPkg.sv
package fpsPkg;
  localparam int WORD_W   = 32;
  localparam int FLAG_W   = 5;
  localparam int FLAG_LSB = 27;
  localparam int QLEN     = 10;
  localparam int QTOP     = 21;
  localparam int CBIT     = 26;
  localparam int TGT_MAX  = QLEN + 1;
  localparam int POS_W    = $clog2(WORD_W);

  typedef struct packed {
    logic             doWrite;
    logic             doMerge;
    logic             doTarget;
    logic             doQueue;
    logic             cmpBit;
    logic [POS_W-1:0] bitPos;
  } fpsStrobe_t;
endpackage

// File: rtl/fpsCtrl.sv
module fpsCtrl
  import fpsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              opDone,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic              cmpDone,
  input  logic [1:0]        cmpRel,
  input  logic [4:0]        cmpMask,
  input  logic [3:0]        cmpTarget,
  input  logic [WORD_W-1:0] statusWord,
  output fpsStrobe_t        strobe,
  output logic              trapReq
);
  logic relBit;
  logic tgtValid;
  logic anyDone;

  always_comb begin
    case (cmpRel)
      2'd0:    relBit = cmpMask[4];
      2'd1:    relBit = cmpMask[3];
      2'd2:    relBit = cmpMask[2];
      default: relBit = cmpMask[1];
    endcase
  end

  assign anyDone  = opDone | cmpDone;
  assign tgtValid = (cmpTarget != 4'd0) && (int'(cmpTarget) <= TGT_MAX);

  always_comb begin
    strobe          = '0;
    strobe.doWrite  = wrEn;
    strobe.doMerge  = !wrEn && anyDone && (opFlags != '0);
    strobe.doTarget = !wrEn && cmpDone && tgtValid;
    strobe.doQueue  = !wrEn && cmpDone && (cmpTarget == 4'd0);
    strobe.cmpBit   = relBit;
    strobe.bitPos   = POS_W'(QTOP + 1 - int'(cmpTarget));
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= strobe.doMerge && ((opFlags & statusWord[FLAG_W-1:0]) != '0);
  end

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ($past(anyDone) && !$past(wrEn) && ($past(opFlags) != '0))); // R6
  AST_TRAP_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && anyDone && ((opFlags & statusWord[FLAG_W-1:0]) != '0)) |=> trapReq); // R6
  AST_WRITE_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !trapReq); // R2
endmodule

// File: rtl/fpsDatapath.sv
module fpsDatapath
  import fpsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpsStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [FLAG_W-1:0] opFlags,
  output logic [WORD_W-1:0] statusWord
);
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    nextWord = statusWord;
    if (strobe.doWrite) begin
      nextWord = wrData;
    end else begin
      if (strobe.doMerge)
        nextWord[FLAG_LSB +: FLAG_W] = statusWord[FLAG_LSB +: FLAG_W] | opFlags;
      if (strobe.doTarget)
        nextWord[strobe.bitPos] = strobe.cmpBit;
      if (strobe.doQueue) begin
        nextWord[QTOP-1 -: QLEN] = statusWord[QTOP -: QLEN];
        nextWord[QTOP]           = statusWord[CBIT];
        nextWord[CBIT]           = strobe.cmpBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusWord <= '0;
    else       statusWord <= nextWord;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |=> (statusWord == $past(wrData))); // R2
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doWrite |=> ((statusWord[WORD_W-1:FLAG_LSB] & $past(statusWord[WORD_W-1:FLAG_LSB]))
                          == $past(statusWord[WORD_W-1:FLAG_LSB]))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doWrite && !strobe.doMerge && !strobe.doTarget && !strobe.doQueue) |=> $stable(statusWord)); // R5
  AST_TARGET_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doTarget |=> (statusWord[$past(strobe.bitPos)] == $past(strobe.cmpBit))); // R8
  AST_QUEUE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doQueue |=> ((statusWord[CBIT] == $past(strobe.cmpBit))
                        && (statusWord[QTOP] == $past(statusWord[CBIT])))); // R9
endmodule

// File: rtl/fpStatusUnit.sv
module fpStatusUnit
  import fpsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              opDone,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic              cmpDone,
  input  logic [1:0]        cmpRel,
  input  logic [4:0]        cmpMask,
  input  logic [3:0]        cmpTarget,
  output logic [WORD_W-1:0] statusWord,
  output logic [1:0]        roundMode,
  output logic              flushEn,
  output logic              trapReq
);
  fpsStrobe_t strobe;

  fpsCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opDone(opDone), .opFlags(opFlags),
    .cmpDone(cmpDone), .cmpRel(cmpRel), .cmpMask(cmpMask), .cmpTarget(cmpTarget),
    .statusWord(statusWord), .strobe(strobe), .trapReq(trapReq)
  );

  fpsDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .opFlags(opFlags), .statusWord(statusWord)
  );

  assign roundMode = statusWord[10:9];
  assign flushEn   = statusWord[5];

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> (statusWord == '0 && !trapReq)); // R1
endmodule

// File: tb/fpStatusUnit_tb.sv
module fpStatusUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        opDone = 1'b0;
  logic [4:0]  opFlags = '0;
  logic        cmpDone = 1'b0;
  logic [1:0]  cmpRel = '0;
  logic [4:0]  cmpMask = '0;
  logic [3:0]  cmpTarget = '0;
  logic [31:0] statusWord;
  logic [1:0]  roundMode;
  logic        flushEn;
  logic        trapReq;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  fpStatusUnit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .opDone(opDone),
    .opFlags(opFlags), .cmpDone(cmpDone), .cmpRel(cmpRel), .cmpMask(cmpMask),
    .cmpTarget(cmpTarget), .statusWord(statusWord), .roundMode(roundMode),
    .flushEn(flushEn), .trapReq(trapReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    wrEn = 0; opDone = 0; cmpDone = 0; opFlags = '0; cmpMask = '0; cmpRel = '0; cmpTarget = '0;
  endtask

  // apply inputs for one clock edge, then sample at the following falling edge
  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic writeWord(input logic [31:0] v);
    wrEn = 1; wrData = v;
    stepCycle();
  endtask

  task automatic doOp(input logic [4:0] f);
    opDone = 1; opFlags = f;
    stepCycle();
  endtask

  task automatic doCmp(input logic [1:0] rel, input logic [4:0] mask, input logic [3:0] y,
                       input logic [4:0] f);
    cmpDone = 1; cmpRel = rel; cmpMask = mask; cmpTarget = y; opFlags = f;
    stepCycle();
  endtask

  task automatic tReset();
    check("R1 word", statusWord, 32'h0);
    check("R1 round", 32'(roundMode), 32'h0);
    check("R1 flush", 32'(flushEn), 32'h0);
    check("R1 trap", 32'(trapReq), 32'h0);
  endtask

  task automatic tWriteControls();
    for (int m = 0; m < 4; m++) begin
      writeWord((32'(m) << 9) | ((m % 2 == 1) ? 32'h20 : 32'h0));
      check("R3 roundMode", 32'(roundMode), 32'(m));
      check("R3 flushEn", 32'(flushEn), (m % 2 == 1) ? 32'h1 : 32'h0);
    end
    writeWord(32'h0000_0420);
    check("R2 write", statusWord, 32'h0000_0420);
  endtask

  task automatic tWritePriority();
    writeWord(32'h0000_001F);
    wrEn = 1; wrData = 32'h0000_0003; opDone = 1; opFlags = 5'h1F;
    cmpDone = 1; cmpRel = 2'd0; cmpMask = 5'h10; cmpTarget = 4'd0;
    stepCycle();
    check("R2 priority word", statusWord, 32'h0000_0003);
    check("R2 priority trap", 32'(trapReq), 32'h0);
  endtask

  task automatic tFlags();
    writeWord(32'h0);
    doOp(5'b00101);
    check("R4 merge", statusWord, 32'h2800_0000);
    check("R6 disabled no trap", 32'(trapReq), 32'h0);
    doOp(5'b00000);
    check("R5 no flags", statusWord, 32'h2800_0000);
    doOp(5'b00010);
    check("R4 sticky", statusWord, 32'h3800_0000);
  endtask

  task automatic tTrap();
    writeWord(32'h0000_0004);
    doOp(5'b00100);
    check("R6 trap raised", 32'(trapReq), 32'h1);
    check("R4 trap word", statusWord, 32'h2000_0004);
    stepCycle();
    check("R6 pulse ends", 32'(trapReq), 32'h0);
    doOp(5'b00001);
    check("R6 other flag no trap", 32'(trapReq), 32'h0);
  endtask

  task automatic tTarget();
    writeWord(32'h0);
    doCmp(2'd0, 5'b10000, 4'd1, 5'd0);
    check("R8 y1 greater", statusWord, 32'h0020_0000);
    doCmp(2'd2, 5'b00100, 4'd11, 5'd0);
    check("R8 y11 equal", statusWord, 32'h0020_0800);
    doCmp(2'd1, 5'b01000, 4'd3, 5'd0);
    check("R7 less bit3", statusWord, 32'h0028_0800);
    doCmp(2'd3, 5'b11101, 4'd1, 5'd0);
    check("R7 unordered bit1 clear", statusWord, 32'h0008_0800);
    doCmp(2'd0, 5'b00001, 4'd3, 5'd0);
    check("R7 mask bit0 only", statusWord, 32'h0000_0800);
  endtask

  task automatic tQueue();
    writeWord(32'h0420_1000);
    doCmp(2'd2, 5'b11011, 4'd0, 5'd0);
    check("R9 push 0", statusWord, 32'h0030_0800);
    doCmp(2'd0, 5'b10000, 4'd0, 5'd0);
    check("R9 push 1", statusWord, 32'h0418_0000);
  endtask

  task automatic tCmpFlags();
    writeWord(32'h0000_0010);
    doCmp(2'd3, 5'b00010, 4'd0, 5'b10000);
    check("R10 merge then push", statusWord, 32'h8400_0010);
    check("R10 compare trap", 32'(trapReq), 32'h1);
  endtask

  task automatic tBadTarget();
    writeWord(32'h0);
    doCmp(2'd0, 5'b10000, 4'd13, 5'b00001);
    check("R11 target out of range", statusWord, 32'h0800_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tWriteControls();
    tWritePriority();
    tFlags();
    tTrap();
    tTarget();
    tQueue();
    tCmpFlags();
    tBadTarget();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule